// File: doc/BRIEF.md
# Dual Cascadable Down-Counting Timer

This block holds two periodic down-counters driven by a shared 10 µs tick. A prescaler divides the system clock to make that tick. The counters run in one of two modes. In split mode they are two separate 16-bit timers. In cascaded mode they join into one 32-bit timer, and that timer is controlled through the timer 1 enable.

When a timer's enable goes high, the timer loads its reload value. It then counts down by one on each tick. When the count is 1 and a tick arrives, the timer reloads and gives a one-cycle expiry pulse to the interrupt logic. A count of zero means the timer is stopped.

A single 32-bit read-only status word shows the live counts. In split mode the upper half holds timer 1 and the lower half holds timer 2. In cascaded mode the whole word is the one 32-bit count.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, status_o is zero, both expiry outputs are low and mode32_o is 0 (split mode).
- R2: A running count changes by exactly one every TICK_DIV clock cycles.
- R3: A rising edge on a timer's enable loads its reload value. The loaded value shows in status_o in the next cycle. This takes priority over a tick in the same cycle.
- R4: While a timer's enable is low, its count is forced to zero from the next cycle on.
- R5: A reload value of zero leaves the timer at zero. It does not count, and it gives no expiry pulse.
- R6: In split mode (mode32_o = 0), status_o[31:16] is the timer 1 count and status_o[15:0] is the timer 2 count.
- R7: A tick that meets a count of 1 makes the timer take its reload value on that same edge. The matching expiry output is high for exactly one cycle.
- R8: In cascaded mode (mode32_o = 1), the value loaded is {reload1_i, reload2_i}, and status_o is the full 32-bit count. expire2_o stays low, and en2_i has no effect.
- R9: A change on mode32_i is taken only when both counts are zero. Otherwise mode32_o holds its value.
- R10: In cascaded mode the count decrements across the half-word boundary. For example, 0x00010000 becomes 0x0000FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode32_i | input | 1 | Requested mode: 0 split, 1 cascaded |
| en1_i | input | 1 | Timer 1 enable (the 32-bit timer in cascaded mode) |
| en2_i | input | 1 | Timer 2 enable (ignored in cascaded mode) |
| reload1_i | input | 16 | Timer 1 reload, or the upper half in cascaded mode |
| reload2_i | input | 16 | Timer 2 reload, or the lower half in cascaded mode |
| status_o | output | 32 | Live count word; layout depends on mode |
| expire1_o | output | 1 | One-cycle expiry pulse of timer 1 |
| expire2_o | output | 1 | One-cycle expiry pulse of timer 2 |
| mode32_o | output | 1 | Mode currently in effect |

## Verification
The bench checks the expiry edge. A design that reloads one tick late would show a count of zero, or a pulse next to the wrong value. It also attempts a mode switch while a timer is running. A design that takes the switch at once would corrupt the status layout of a running count. In cascaded mode the bench starts from a count of 0x00010000, because a design that lets the two halves decrement separately would wrap to 0x0001FFFF. It also checks that a zero reload and a held enable on timer 2 in cascaded mode do nothing. A wrong design would show counting or stray pulses.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic {
    MODE_SPLIT   = 1'b0,
    MODE_CASCADE = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int unsigned DIV = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         en_q;
  logic         start;
  logic         hit;

  assign start = en_i & ~en_q;
  assign hit   = en_i & ~start & tick_i & (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      en_q     <= 1'b0;
      expire_o <= 1'b0;
    end else begin
      en_q     <= en_i;
      expire_o <= hit;
      if (!en_i)                          cnt_q <= '0;
      else if (start || hit)              cnt_q <= reload_i;
      else if (tick_i && cnt_q != '0)     cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mode_ctl.sv
module mode_ctl
  import timer_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  logic      idle_i,
  output tmr_mode_e mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_o <= MODE_SPLIT;
    else if (idle_i) mode_o <= req_i ? MODE_CASCADE : MODE_SPLIT;
  end
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import timer_pkg::*;
#(
  parameter int unsigned TICK_DIV = 500,
  parameter int unsigned HALF_W   = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mode32_i,
  input  logic                  en1_i,
  input  logic                  en2_i,
  input  logic [HALF_W-1:0]     reload1_i,
  input  logic [HALF_W-1:0]     reload2_i,
  output logic [2*HALF_W-1:0]   status_o,
  output logic                  expire1_o,
  output logic                  expire2_o,
  output logic                  mode32_o
);
  localparam int unsigned FULL_W = 2 * HALF_W;

  logic              tick;
  tmr_mode_e         mode;
  logic              cascade;
  logic [FULL_W-1:0] rel1;
  logic [FULL_W-1:0] cnt1;
  logic [HALF_W-1:0] cnt2;
  logic              en2_eff;

  tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  assign cascade = (mode == MODE_CASCADE);
  assign rel1    = cascade ? {reload1_i, reload2_i} : {{HALF_W{1'b0}}, reload1_i};
  assign en2_eff = en2_i & ~cascade;

  // timer 1 is full width so it serves both modes
  tmr_channel #(.W(FULL_W)) u_t1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .en_i    (en1_i),
    .reload_i(rel1),
    .cnt_o   (cnt1),
    .expire_o(expire1_o)
  );

  tmr_channel #(.W(HALF_W)) u_t2 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .en_i    (en2_eff),
    .reload_i(reload2_i),
    .cnt_o   (cnt2),
    .expire_o(expire2_o)
  );

  mode_ctl u_mode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (mode32_i),
    .idle_i((cnt1 == '0) && (cnt2 == '0)),
    .mode_o(mode)
  );

  assign status_o = cascade ? cnt1 : {cnt1[HALF_W-1:0], cnt2};
  assign mode32_o = cascade;
endmodule

// File: rtl/dual_down_timer_chk.sv
module dual_down_timer_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en1_i,
  input logic [W-1:0] status_o,
  input logic         expire1_o,
  input logic         expire2_o,
  input logic         mode32_o
);
  // R7
  exp1_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire1_o |=> !expire1_o);
  // R7
  exp2_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire2_o |=> !expire2_o);
  // R8
  cascade_no_exp2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode32_o |-> !expire2_o);
  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != '0) |=> $stable(mode32_o));
  // R4
  disable_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en1_i |=> (mode32_o ? (status_o == '0) : (status_o[W-1:W/2] == '0)));
endmodule

bind dual_down_timer dual_down_timer_chk #(.W(2 * HALF_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en1_i    (en1_i),
  .status_o (status_o),
  .expire1_o(expire1_o),
  .expire2_o(expire2_o),
  .mode32_o (mode32_o)
);

// File: tb/sim_dual_down_timer.sv
`timescale 1ns/1ps
module sim_dual_down_timer;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode32 = 1'b0, en1 = 1'b0, en2 = 1'b0;
  logic [15:0] r1 = '0, r2 = '0;
  logic [31:0] status;
  logic        exp1, exp2, mode_o;

  int errors = 0, checks = 0;
  logic exp2_seen = 1'b0, exp1_seen = 1'b0;

  always #10 clk = ~clk;

  dual_down_timer #(.TICK_DIV(D), .HALF_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode32_i(mode32), .en1_i(en1), .en2_i(en2),
    .reload1_i(r1), .reload2_i(r2), .status_o(status),
    .expire1_o(exp1), .expire2_o(exp2), .mode32_o(mode_o)
  );

  always @(posedge clk) begin
    if (exp2) exp2_seen <= 1'b1;
    if (exp1) exp1_seen <= 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic stop_all();
    @(negedge clk); en1 = 0; en2 = 0;
    repeat (2) @(negedge clk);
  endtask

  // {mode, reload1, reload2, expected status}
  localparam logic [64:0] VEC [6] = '{
    {1'b0, 16'h1234, 16'hABCD, 32'h1234ABCD},
    {1'b0, 16'hFFFF, 16'h0001, 32'hFFFF0001},
    {1'b1, 16'h1234, 16'hABCD, 32'h1234ABCD},
    {1'b1, 16'h0000, 16'h0005, 32'h00000005},
    {1'b0, 16'h0000, 16'h0007, 32'h00000007},
    {1'b1, 16'hFFFF, 16'hFFFF, 32'hFFFFFFFF}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] prev;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status", status, 32'h0);
    check("R1 expire", {30'd0, exp1, exp2}, 32'h0);
    check("R1 mode", {31'd0, mode_o}, 32'h0);

    // R3 R6 R8: load and packing
    for (int i = 0; i < 6; i++) begin
      stop_all();
      mode32 = VEC[i][64]; r1 = VEC[i][63:48]; r2 = VEC[i][47:32];
      repeat (2) @(negedge clk);
      en1 = 1; en2 = 1;
      @(negedge clk);
      check(VEC[i][64] ? "R8 load" : "R6 R3 load", status, VEC[i][31:0]);
      check("R8 mode", {31'd0, mode_o}, {31'd0, VEC[i][64]});
    end

    // R2: tick spacing
    stop_all();
    mode32 = 0; r1 = 16'd5; r2 = 16'd0;
    repeat (2) @(negedge clk);
    en1 = 1;
    @(negedge clk);
    prev = status;
    n = 0;
    while (status == prev && n < 50) begin @(negedge clk); n++; end
    prev = status; n = 0;
    while (status == prev && n < 50) begin @(negedge clk); n++; end
    check("R2 period", n, D);

    // R7: reload on expiry, one-cycle pulse
    stop_all();
    r1 = 16'd3;
    en1 = 1;
    @(negedge clk);
    prev = status; n = 0;
    while (!exp1 && n < 100) begin prev = status; @(negedge clk); n++; end
    check("R7 before", {16'd0, prev[31:16]}, 32'd1);
    check("R7 reloaded", {16'd0, status[31:16]}, 32'd3);
    @(negedge clk);
    check("R7 pulse width", {31'd0, exp1}, 32'd0);

    // R9: mode change ignored while running
    mode32 = 1;
    repeat (10) @(negedge clk);
    check("R9 held", {31'd0, mode_o}, 32'd0);
    en1 = 0; en2 = 0;
    repeat (3) @(negedge clk);
    check("R9 taken", {31'd0, mode_o}, 32'd1);

    // R10: cascade borrow across halves
    r1 = 16'h0001; r2 = 16'h0000;
    en1 = 1;
    @(negedge clk);
    check("R10 load", status, 32'h00010000);
    n = 0;
    while (status == 32'h00010000 && n < 50) begin @(negedge clk); n++; end
    check("R10 borrow", status, 32'h0000FFFF);

    // R8: cascade expiry, en2 ignored
    stop_all();
    exp2_seen = 0;
    r1 = 16'h0000; r2 = 16'h0002; en2 = 1;
    @(negedge clk);
    check("R8 en2 ignored", status, 32'h0);
    en1 = 1;
    n = 0;
    while (!exp1 && n < 100) begin @(negedge clk); n++; end
    check("R8 cascade expire", {31'd0, exp1}, 32'd1);
    check("R8 cascade reload", status, 32'h00000002);
    repeat (3 * D) @(negedge clk);
    check("R8 no expire2", {31'd0, exp2_seen}, 32'd0);

    // R4: disable forces zero
    @(negedge clk); en1 = 0;
    @(negedge clk);
    check("R4 disable", status, 32'h0);

    // R5: zero reload stays stopped
    mode32 = 0; en2 = 0;
    repeat (3) @(negedge clk);
    r1 = 0; r2 = 0;
    exp1_seen = 0; exp2_seen = 0;
    en1 = 1; en2 = 1;
    repeat (4 * D) @(negedge clk);
    check("R5 stopped", status, 32'h0);
    check("R5 no pulse", {30'd0, exp1_seen, exp2_seen}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule